// File: doc/BRIEF.md
# I2C Register Slave with Packet Error Checking

This block is a byte-wide register-access slave on a two-wire I2C bus. SCL and SDA enter through a synchroniser. The block finds START, repeated START and STOP on the sampled lines and pulls SDA low through an open-drain enable. It answers one 7-bit slave address. The first byte after the address sets an 8-bit location pointer into an internal array of 256 bytes.

An input selects one of two framings. In plain framing, a write stores bytes from the pointer onward, limited to a short page. A read returns bytes from the pointer while the master acknowledges each one.

In checked framing, a length byte follows the pointer. A CRC-8 with polynomial x^8+x^2+x+1 and initial value 00h runs over the pointer, the length and the data, MSB first. A checked read sends the requested bytes and then the CRC byte. A checked write holds its data in a staging buffer. The data reaches the array only when the CRC byte from the master matches.

Top module: `i2c_pec_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1010000 (A0h to write, A1h to read). Any other address is not acknowledged, and every later byte is ignored and left unacknowledged until the next START.
- R2: Bytes in both directions travel MSB first. While SCL is high during a byte sent by the slave, SDA does not change.
- R3: In plain write framing, the byte after the address loads the pointer. Each following data byte is acknowledged, stored at the pointer, and the pointer then steps by one, wrapping from FFh to 00h. The array has a single write source in any cycle.
- R4: In plain framing, one write transaction stores at most 4 data bytes. The fifth data byte is not acknowledged and is not stored.
- R5: A read address returns the byte at the pointer, and the pointer steps by one after each byte. Bytes continue while the master acknowledges. A pointer set by a write phase followed by a repeated START selects where the read begins.
- R6: In checked framing, the byte after the pointer is a length. A length of 0 or above 128 is not acknowledged.
- R7: A checked read (pointer, length, repeated START, A1h) returns exactly that many data bytes and then the CRC-8 computed over the pointer, the length and the returned bytes.
- R8: In a checked write, the byte that follows the stated number of data bytes is a CRC. When it matches, it is acknowledged, the data is committed to consecutive locations (wrapping at FFh), and the pointer advances by the length.
- R9: When the CRC of a checked write does not match, it is not acknowledged and none of the data is stored. A STOP before the CRC byte also discards the data.
- R10: In checked framing, a read address that no valid length precedes in the same transaction is not acknowledged.
- R11: The pointer keeps its value across a STOP, so a later plain read starts where the previous access left it.
- R12: The slave's SDA pull-down only starts while SCL is low.
- R13: Under reset, and after it, the slave does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, sampling the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pec_en_i | input | 1 | 1 selects checked framing with length and CRC |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |

## Verification
Each bus line passes through two synchroniser stages and an edge register. An acknowledge or a data bit therefore appears on sda_oe_o three clocks after the SCL fall that starts its slot. The bench master holds SCL low for ten clocks and reads SDA in the middle of the high phase, well after that point. A committed checked write takes one clock per byte after the CRC byte. The bench waits at least a full STOP and START before reading it back, and it compares every acknowledge and returned byte against its own array and CRC model. A monitor on every clock checks that the pull-down never changes while SCL is high.

// File: rtl/i2c_pec_pkg.sv
package i2c_pec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK1, ST_ACK2, ST_TX, ST_TXACK, ST_TXNEXT
  } state_e;

  typedef enum logic [2:0] {
    ROLE_DEV, ROLE_PTR, ROLE_CNT, ROLE_DATA, ROLE_CRC, ROLE_DONE
  } role_e;

  typedef enum logic [1:0] {
    TXK_DATA, TXK_CRC, TXK_FILL
  } txkind_e;
endpackage

// File: rtl/i2c_pec_sync.sv
module i2c_pec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_pec_crc8.sv
module i2c_pec_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  always_comb begin
    logic [7:0] c;
    c = crc_i;
    for (int i = 7; i >= 0; i--) begin
      c = {c[6:0], 1'b0} ^ ((c[7] ^ data_i[i]) ? POLY : 8'h00);
    end
    crc_o = c;
  end
endmodule

// File: rtl/i2c_pec_stage.sv
module i2c_pec_stage #(
  parameter int DEPTH = 128,
  parameter int AW    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [$clog2(DEPTH)-1:0] widx_i,
  input  logic [7:0]               wdata_i,
  input  logic                     go_i,
  input  logic [AW-1:0]            base_i,
  input  logic [$clog2(DEPTH):0]   len_i,
  output logic                     we_o,
  output logic [AW-1:0]            waddr_o,
  output logic [7:0]               wdata_o
);
  localparam int IW = $clog2(DEPTH);

  logic [7:0]    buf_q [DEPTH];
  logic          busy_q;
  logic [IW:0]   i_q, len_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) buf_q[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      i_q    <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      i_q    <= '0;
      len_q  <= len_i;
      base_q <= base_i;
    end else if (busy_q) begin
      i_q <= i_q + (IW+1)'(1);
      if (i_q + (IW+1)'(1) == len_q) busy_q <= 1'b0;
    end
  end

  assign we_o    = busy_q;
  assign waddr_o = base_q + AW'(i_q);
  assign wdata_o = buf_q[i_q[IW-1:0]];

  assert_commit_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (len_i != '0 && len_i <= (IW+1)'(DEPTH)));
  assert_no_go_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
  assert_no_fill_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !busy_q);
endmodule

// File: rtl/i2c_pec_regs.sv
module i2c_pec_regs #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_pec_slave.sv
module i2c_pec_slave
  import i2c_pec_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h50,
  parameter int         MAX_CNT     = 128,
  parameter int         PAGE_BYTES  = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pec_en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW    = 8;
  localparam int IDX_W = $clog2(MAX_CNT);
  localparam int PG_W  = $clog2(PAGE_BYTES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_pec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  state_e        st_q;
  role_e         role_q;
  txkind_e       kind_q, nxt_kind;
  logic [3:0]    bit_q;
  logic [6:0]    sh_q;
  logic [7:0]    ptr_q, crc_q, cnt_q, left_q, tx_q, nxt_byte, rd_data;
  logic [PG_W-1:0] page_q;
  logic          cnt_valid_q, crc_sent_q, ack_q, go_tx_q, sda_oe_q;

  logic [7:0] rx_byte, crc_rx_in, crc_rx, crc_tx;
  logic       byte_done;
  assign rx_byte   = {sh_q, sda_s};
  assign byte_done = (st_q == ST_RX) && scl_rise && (bit_q == 4'd7) && !start_ev && !stop_ev;
  assign crc_rx_in = (role_q == ROLE_PTR) ? 8'h00 : crc_q;

  i2c_pec_crc8 u_crc_rx (.crc_i(crc_rx_in), .data_i(rx_byte), .crc_o(crc_rx));
  i2c_pec_crc8 u_crc_tx (.crc_i(crc_q),     .data_i(tx_q),    .crc_o(crc_tx));

  // write sources into the array
  logic fsm_we, stg_fill, commit_go, stg_we, reg_we;
  logic [AW-1:0] stg_waddr, reg_waddr;
  logic [7:0]    stg_wdata, reg_wdata;

  assign fsm_we    = byte_done && role_q == ROLE_DATA && !pec_en_i && page_q < PG_W'(PAGE_BYTES);
  assign stg_fill  = byte_done && role_q == ROLE_DATA && pec_en_i;
  assign commit_go = byte_done && role_q == ROLE_CRC && rx_byte == crc_q;

  i2c_pec_stage #(.DEPTH(MAX_CNT), .AW(AW)) u_stage (
    .clk_i, .rst_ni,
    .wr_i(stg_fill), .widx_i(IDX_W'(cnt_q - left_q)), .wdata_i(rx_byte),
    .go_i(commit_go), .base_i(ptr_q), .len_i(cnt_q[IDX_W:0]),
    .we_o(stg_we), .waddr_o(stg_waddr), .wdata_o(stg_wdata)
  );

  assign reg_we    = fsm_we | stg_we;
  assign reg_waddr = stg_we ? stg_waddr : ptr_q;
  assign reg_wdata = stg_we ? stg_wdata : rx_byte;

  i2c_pec_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we), .waddr_i(reg_waddr), .wdata_i(reg_wdata),
    .raddr_i(ptr_q), .rdata_o(rd_data)
  );

  // next byte to transmit
  always_comb begin
    if (!pec_en_i || left_q != 8'h00) begin
      nxt_kind = TXK_DATA;
      nxt_byte = rd_data;
    end else if (!crc_sent_q) begin
      nxt_kind = TXK_CRC;
      nxt_byte = crc_q;
    end else begin
      nxt_kind = TXK_FILL;
      nxt_byte = 8'hFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      role_q      <= ROLE_DEV;
      kind_q      <= TXK_FILL;
      bit_q       <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      crc_q       <= '0;
      cnt_q       <= '0;
      left_q      <= '0;
      tx_q        <= '0;
      page_q      <= '0;
      cnt_valid_q <= 1'b0;
      crc_sent_q  <= 1'b0;
      ack_q       <= 1'b0;
      go_tx_q     <= 1'b0;
      sda_oe_q    <= 1'b0;
    end else if (stop_ev) begin
      st_q        <= ST_IDLE;
      sda_oe_q    <= 1'b0;
      cnt_valid_q <= 1'b0;
    end else if (start_ev) begin
      st_q     <= ST_RX;
      role_q   <= ROLE_DEV;
      bit_q    <= '0;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: if (scl_rise) begin
          sh_q  <= rx_byte[6:0];
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            st_q    <= ST_ACK1;
            ack_q   <= 1'b0;
            go_tx_q <= 1'b0;
            unique case (role_q)
              ROLE_DEV: if (rx_byte[7:1] == SLAVE_ADDR) begin
                if (!rx_byte[0]) begin
                  ack_q  <= 1'b1;
                  role_q <= ROLE_PTR;
                end else if (!pec_en_i || cnt_valid_q) begin
                  ack_q      <= 1'b1;
                  go_tx_q    <= 1'b1;
                  crc_sent_q <= 1'b0;
                  role_q     <= ROLE_DONE;
                end
              end
              ROLE_PTR: begin
                ack_q       <= 1'b1;
                ptr_q       <= rx_byte;
                crc_q       <= crc_rx;
                page_q      <= '0;
                cnt_valid_q <= 1'b0;
                role_q      <= pec_en_i ? ROLE_CNT : ROLE_DATA;
              end
              ROLE_CNT: if (rx_byte != 8'h00 && rx_byte <= 8'(MAX_CNT)) begin
                ack_q       <= 1'b1;
                cnt_q       <= rx_byte;
                left_q      <= rx_byte;
                crc_q       <= crc_rx;
                cnt_valid_q <= 1'b1;
                role_q      <= ROLE_DATA;
              end
              ROLE_DATA: if (pec_en_i) begin
                ack_q       <= 1'b1;
                crc_q       <= crc_rx;
                left_q      <= left_q - 8'd1;
                cnt_valid_q <= 1'b0;
                if (left_q == 8'd1) role_q <= ROLE_CRC;
              end else if (page_q < PG_W'(PAGE_BYTES)) begin
                ack_q  <= 1'b1;
                ptr_q  <= ptr_q + 8'd1;
                page_q <= page_q + PG_W'(1);
              end
              ROLE_CRC: begin
                if (rx_byte == crc_q) begin
                  ack_q <= 1'b1;
                  ptr_q <= ptr_q + cnt_q;
                end
                role_q <= ROLE_DONE;
              end
              default: ack_q <= 1'b0;
            endcase
          end
        end
        ST_ACK1: if (scl_fall) begin
          sda_oe_q <= ack_q;
          st_q     <= ST_ACK2;
        end
        ST_ACK2: if (scl_fall) begin
          bit_q <= '0;
          if (!ack_q) begin
            sda_oe_q <= 1'b0;
            st_q     <= ST_IDLE;
          end else if (go_tx_q) begin
            tx_q     <= nxt_byte;
            kind_q   <= nxt_kind;
            sda_oe_q <= ~nxt_byte[7];
            st_q     <= ST_TX;
          end else begin
            sda_oe_q <= 1'b0;
            st_q     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_q <= bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              sda_oe_q <= 1'b0;
              st_q     <= ST_TXACK;
            end else begin
              sda_oe_q <= ~tx_q[~bit_q[2:0]];
            end
          end
        end
        ST_TXACK: if (scl_rise) begin
          if (kind_q == TXK_DATA) begin
            ptr_q <= ptr_q + 8'd1;
            if (pec_en_i) begin
              crc_q  <= crc_tx;
              left_q <= left_q - 8'd1;
            end
          end else if (kind_q == TXK_CRC) begin
            crc_sent_q <= 1'b1;
          end
          st_q <= sda_s ? ST_IDLE : ST_TXNEXT;
        end
        ST_TXNEXT: if (scl_fall) begin
          bit_q    <= '0;
          tx_q     <= nxt_byte;
          kind_q   <= nxt_kind;
          sda_oe_q <= ~nxt_byte[7];
          st_q     <= ST_TX;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  assert_oe_rise_scl_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_s);
  assert_tx_bit_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX && $past(st_q == ST_TX) && scl_s && $past(scl_s)) |-> $stable(sda_oe_q));
  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_valid_q |-> (cnt_q != 8'h00 && cnt_q <= 8'(MAX_CNT)));
  assert_page_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_q <= PG_W'(PAGE_BYTES));
  assert_one_writer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fsm_we, stg_we}));
endmodule

// File: tb/i2c_pec_slave_tb.sv
module i2c_pec_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0, pec_en = 1'b0, m_scl = 1'b1, m_low = 1'b0;
  logic sda_oe, sda_bus;
  assign sda_bus = !(m_low || sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pec_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pec_en_i(pec_en),
    .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  int n_vec = 0, n_bad = 0, r12_viol = 0;
  logic [7:0] mm [256];
  logic [7:0] dq [$];
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(logic [7:0] c, logic [7:0] b);
    int v = int'(c ^ b);
    for (int k = 0; k < 8; k++) v = (v & 128) != 0 ? ((v << 1) ^ 7) & 255 : (v << 1) & 255;
    return v[7:0];
  endfunction

  // R12 monitor: pull-down must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_oe !== prev_oe) r12_viol++;
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
  end

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_bit(input logic v, output logic r);
    wq(Q); m_low = !v; wq(Q); m_scl = 1'b1; wq(Q); r = sda_bus; wq(Q); m_scl = 1'b0;
  endtask

  task automatic do_start;
    wq(Q); m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(2*Q); m_low = 1'b1; wq(2*Q); m_scl = 1'b0;
  endtask

  task automatic do_stop;
    wq(Q); m_low = 1'b1; wq(Q); m_scl = 1'b1; wq(2*Q); m_low = 1'b0; wq(4*Q);
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic rb(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, r);
      b = {b[6:0], r};
    end
    bus_bit(!mack, r);
  endtask

  task automatic plain_wr(input logic [7:0] ptr);
    logic a;
    do_start;
    wb(8'hA0, a); chk("R1 write address ACK", a, 1);
    wb(ptr, a);   chk("R3 pointer ACK", a, 1);
    for (int i = 0; i < dq.size(); i++) begin
      wb(dq[i], a);
      if (i < 4) begin
        chk("R3 data ACK", a, 1);
        mm[8'(ptr + i)] = dq[i];
      end else begin
        chk("R4 byte past page NACK", a, 0);
      end
    end
    do_stop;
  endtask

  task automatic plain_rd(input logic [7:0] ptr, input int n);
    logic a; logic [7:0] b;
    do_start;
    wb(8'hA0, a); chk("R5 dummy write ACK", a, 1);
    wb(ptr, a);   chk("R5 pointer ACK", a, 1);
    do_start;
    wb(8'hA1, a); chk("R1 read address ACK", a, 1);
    for (int i = 0; i < n; i++) begin
      rb(i != n - 1, b);
      chk("R5 R2 read data MSB first", b, mm[8'(ptr + i)]);
    end
    do_stop;
  endtask

  task automatic pec_wr(input logic [7:0] ptr, input logic bad);
    logic a; logic [7:0] c;
    do_start;
    wb(8'hA0, a); chk("R1 write address ACK", a, 1);
    wb(ptr, a);   chk("R8 pointer ACK", a, 1);
    wb(8'(dq.size()), a); chk("R6 valid length ACK", a, 1);
    c = ref_crc(8'h00, ptr);
    c = ref_crc(c, 8'(dq.size()));
    for (int i = 0; i < dq.size(); i++) begin
      wb(dq[i], a); chk("R8 checked data ACK", a, 1);
      c = ref_crc(c, dq[i]);
    end
    wb(bad ? c ^ 8'h5A : c, a);
    if (bad) chk("R9 wrong CRC NACK", a, 0);
    else     chk("R8 matching CRC ACK", a, 1);
    do_stop;
    if (!bad) for (int i = 0; i < dq.size(); i++) mm[8'(ptr + i)] = dq[i];
  endtask

  task automatic pec_rd(input logic [7:0] ptr, input int n);
    logic a; logic [7:0] b, c;
    do_start;
    wb(8'hA0, a); chk("R7 dummy write ACK", a, 1);
    wb(ptr, a);   chk("R7 pointer ACK", a, 1);
    wb(8'(n), a); chk("R6 valid length ACK", a, 1);
    do_start;
    wb(8'hA1, a); chk("R7 read address ACK", a, 1);
    c = ref_crc(ref_crc(8'h00, ptr), 8'(n));
    for (int i = 0; i < n; i++) begin
      rb(1'b1, b);
      chk("R7 checked read data", b, mm[8'(ptr + i)]);
      c = ref_crc(c, mm[8'(ptr + i)]);
    end
    rb(1'b0, b);
    chk("R7 trailing CRC byte", b, c);
    do_stop;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic a; logic [7:0] b;
    for (int i = 0; i < 256; i++) mm[i] = 8'h00;
    wq(4);
    chk("R13 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    wq(8);
    chk("R13 released after reset", sda_oe, 0);

    // R1: foreign address, then ignored until START
    do_start;
    wb(8'h42, a); chk("R1 foreign address NACK", a, 0);
    wb(8'hA0, a); chk("R1 ignored until START", a, 0);
    do_stop;

    dq = '{8'h11, 8'h22, 8'h33};
    plain_wr(8'h10);
    plain_rd(8'h10, 3);

    dq = '{8'hA5, 8'h5A, 8'hC3};
    plain_wr(8'hFE);
    plain_rd(8'hFE, 3);

    dq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    plain_wr(8'h20);
    plain_rd(8'h20, 5);

    // R11: pointer survives STOP
    do_start; wb(8'hA0, a); wb(8'h11, a); do_stop;
    do_start;
    wb(8'hA1, a); chk("R11 read after STOP ACK", a, 1);
    rb(1'b0, b);  chk("R11 pointer kept across STOP", b, mm[8'h11]);
    do_stop;

    pec_en = 1'b1;
    wq(4);
    do_start; wb(8'hA0, a); wb(8'h30, a);
    wb(8'h00, a); chk("R6 zero length NACK", a, 0);
    do_stop;
    do_start; wb(8'hA0, a); wb(8'h30, a);
    wb(8'd129, a); chk("R6 length 129 NACK", a, 0);
    do_stop;
    do_start; wb(8'hA0, a); wb(8'h30, a);
    wb(8'd128, a); chk("R6 length 128 ACK", a, 1);
    do_stop;

    do_start;
    wb(8'hA1, a); chk("R10 read without length NACK", a, 0);
    do_stop;

    dq = '{8'h9A, 8'hBC, 8'hDE};
    pec_wr(8'h40, 1'b0);
    pec_rd(8'h40, 3);

    dq = '{8'hC1, 8'hC2};
    pec_wr(8'hFF, 1'b0);
    pec_rd(8'hFF, 2);

    dq = '{8'hEE, 8'hEF};
    pec_wr(8'h40, 1'b1);
    pec_rd(8'h40, 3);

    // R9: STOP before CRC discards
    do_start; wb(8'hA0, a); wb(8'h40, a); wb(8'h02, a);
    wb(8'h55, a); wb(8'h66, a);
    do_stop;
    pec_rd(8'h40, 3);

    pec_rd(8'h10, 1);

    chk("R12 pull-down stable while SCL high", r12_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule